// File: doc/BRIEF.md
# Software Interrupt Entry Sequencer

This block carries a CPU core from executing a software interrupt instruction to the first instruction of its handler. A one-cycle trigger from the decoder captures the live register file and a vector number. The sequencer then stores a twelve-byte context frame on the system stack through a byte-wide memory port. Next it reads three vector bytes from the table that hardware interrupts also use, and hands back the new stack pointer, program counter, code bank and status word. A one-cycle completion strobe marks that hand-back.

No interrupt request or enable flag takes part in the entry. The trigger is the only cause. The interrupt level mask field of the status word passes through untouched, because a software interrupt carries no level of its own. Every memory access is held until the memory acknowledges it with a ready signal, so both zero-wait and slow memories can be used. The vector table shares its numbering with hardware interrupts, so vector 11 is the same entry that hardware source 0 uses.

Top module: `swi_entry_seq`

## Requirements
- R1: While reset is held and immediately after it, `busy`, `done` and `mem_req` are 0, and `sp_new`, `pc_new`, `bank_new` and `status_new` are 0.
- R2: `swi_go` starts a sequence only when `busy` is 0. A pulse on `swi_go` while a sequence runs causes no extra memory access, no second `done`, and no change to that sequence's results.
- R3: A sequence first issues exactly 12 byte writes. Write k (k = 0..11) goes to address {`sys_bank`, `sys_sp` − (k+1)}, where the subtraction wraps in 16 bits and the bank is unchanged. The data, in order, is: status[15:8], status[7:0], pc[15:8], pc[7:0], dpage, addr_bank, data_bank, code_bank, acc[31:24], acc[23:16], acc[15:8], acc[7:0].
- R4: The status bytes that are written are the value captured at the trigger, before any flag is changed.
- R5: At `done`, `sp_new` equals the captured `sys_sp` − 12, modulo 2^16.
- R6: After the last write, exactly three reads follow, and no write comes after a read. Read k (k = 0,1,2) goes to {VEC_BANK, VEC_TOP − 4·vec_id + k}, with defaults VEC_BANK = 8'hFF and VEC_TOP = 16'hFFFC.
- R7: At `done`, `pc_new` = {read 1, read 0} and `bank_new` = read 2. These outputs change only in the cycle in which `done` is 1.
- R8: At `done`, `status_new` equals the captured status with bit 6 (interrupt enable) cleared and bit 5 (stack select) set. All other bits are kept, including the level mask in bits 15:13.
- R9: While `mem_req` is 1 and `mem_ready` is 0, the access is held: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged in the next cycle.
- R10: `done` is 1 for exactly one cycle per sequence. In that cycle `busy` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swi_go | input | 1 | Software interrupt trigger from the decoder |
| vec_id | input | 8 | Vector number of the instruction |
| acc | input | 32 | Accumulator |
| dpage | input | 8 | Direct page register |
| addr_bank | input | 8 | Additional data bank |
| data_bank | input | 8 | Data bank |
| code_bank | input | 8 | Current program bank |
| pc | input | 16 | Program counter of the return point |
| status | input | 16 | Processor status word |
| sys_bank | input | 8 | System stack bank |
| sys_sp | input | 16 | System stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access completes at this clock edge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| sp_new | output | 16 | Updated system stack pointer |
| pc_new | output | 16 | Handler program counter |
| bank_new | output | 8 | Handler program bank |
| status_new | output | 16 | Updated status word |

## Verification
The sequencer is run with vector numbers 0, 11 and 255, with memory wait states of 0, 1 and 2, and with a stack pointer near zero. Vector 0 and vector 255 exercise the two ends of the table arithmetic. The low stack pointer makes the frame wrap inside its bank, which separates a 16-bit pointer from a 24-bit one. The status words used have the interrupt enable set with stack select clear, the reverse, and all ones. These tell a captured-then-modified status apart from a live or a partly masked one, and they show that the level mask is kept. A second trigger fired in the middle of a sequence, with a different vector number, shows whether the busy sequencer ignores it.

// File: rtl/swi_entry_seq.sv
`timescale 1ns/1ps
module swi_entry_seq #(
  parameter logic [15:0] VEC_TOP  = 16'hFFFC,
  parameter logic [7:0]  VEC_BANK = 8'hFF,
  parameter int          IBIT     = 6,
  parameter int          SBIT     = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        swi_go,
  input  logic [7:0]  vec_id,
  input  logic [31:0] acc,
  input  logic [7:0]  dpage,
  input  logic [7:0]  addr_bank,
  input  logic [7:0]  data_bank,
  input  logic [7:0]  code_bank,
  input  logic [15:0] pc,
  input  logic [15:0] status,
  input  logic [7:0]  sys_bank,
  input  logic [15:0] sys_sp,
  output logic        mem_req,
  output logic        mem_we,
  output logic [23:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ready,
  output logic        busy,
  output logic        done,
  output logic [15:0] sp_new,
  output logic [15:0] pc_new,
  output logic [7:0]  bank_new,
  output logic [15:0] status_new
);
  localparam int CTX_BYTES = 12;
  localparam int CTX_W     = 8 * CTX_BYTES;
  localparam int VEC_BYTES = 3;

  typedef enum logic [1:0] {IDLE, PUSH, FETCH} st_t;

  st_t              st;
  logic [3:0]       cnt;
  logic [CTX_W-1:0] ctx;
  logic [7:0]       bank_q;
  logic [15:0]      sp_q, ps_q, vaddr_q, vbuf;
  logic [15:0]      ps_upd;

  assign busy      = (st != IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st == PUSH);
  assign mem_wdata = ctx[CTX_W-1 -: 8];
  assign mem_addr  = (st == FETCH) ? {VEC_BANK, vaddr_q + 16'(cnt)}
                                   : {bank_q, sp_q - 16'(cnt) - 16'd1};

  always_comb begin
    ps_upd       = ps_q;
    ps_upd[IBIT] = 1'b0;
    ps_upd[SBIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      cnt        <= '0;
      ctx        <= '0;
      bank_q     <= '0;
      sp_q       <= '0;
      ps_q       <= '0;
      vaddr_q    <= '0;
      vbuf       <= '0;
      done       <= 1'b0;
      sp_new     <= '0;
      pc_new     <= '0;
      bank_new   <= '0;
      status_new <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (swi_go) begin
          ctx     <= {status, pc, dpage, addr_bank, data_bank, code_bank, acc};
          bank_q  <= sys_bank;
          sp_q    <= sys_sp;
          ps_q    <= status;
          vaddr_q <= VEC_TOP - (16'(vec_id) << 2);
          cnt     <= '0;
          st      <= PUSH;
        end
        PUSH: if (mem_ready) begin
          ctx <= ctx << 8;
          if (cnt == 4'(CTX_BYTES - 1)) begin
            cnt <= '0;
            st  <= FETCH;
          end else begin
            cnt <= cnt + 4'd1;
          end
        end
        FETCH: if (mem_ready) begin
          if (cnt == 4'd0) vbuf[7:0]  <= mem_rdata;
          if (cnt == 4'd1) vbuf[15:8] <= mem_rdata;
          if (cnt == 4'(VEC_BYTES - 1)) begin
            pc_new     <= vbuf;
            bank_new   <= mem_rdata;
            status_new <= ps_upd;
            sp_new     <= sp_q - 16'(CTX_BYTES);
            done       <= 1'b1;
            cnt        <= '0;
            st         <= IDLE;
          end else begin
            cnt <= cnt + 4'd1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swi_entry_seq_chk.sv
`timescale 1ns/1ps
module swi_entry_seq_chk #(
  parameter int IBIT = 6,
  parameter int SBIT = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ready,
  input logic [23:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        busy,
  input logic        done,
  input logic [15:0] pc_new,
  input logic [7:0]  bank_new,
  input logic [15:0] status_new
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R9
  AST_NO_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |=> !(mem_req && mem_we)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req); // R10
  AST_FLAGS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !status_new[IBIT] && status_new[SBIT]); // R8
  AST_LOAD_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pc_new) || !$stable(bank_new)) |-> done); // R7
endmodule

bind swi_entry_seq swi_entry_seq_chk u_chk (.*);

// File: tb/tb_swi_entry_seq.sv
`timescale 1ns/1ps
module tb_swi_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swi_go = 1'b0;
  logic [7:0]  vec_id = '0;
  logic [31:0] acc = '0;
  logic [7:0]  dpage = '0, addr_bank = '0, data_bank = '0, code_bank = '0, sys_bank = '0;
  logic [15:0] pc = '0, status = '0, sys_sp = '0;
  logic        mem_req, mem_we, mem_ready, busy, done;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, bank_new;
  logic [15:0] sp_new, pc_new, status_new;

  swi_entry_seq dut (.*);

  always #10 clk = ~clk;

  typedef struct packed { logic [23:0] a; logic [7:0] d; } item_t;
  item_t       wr_q[$];
  logic [23:0] rd_q[$];
  logic [7:0]  mem [logic [23:0]];
  int          waits = 0;
  int          wcnt = 0;
  int          nchk = 0, nfail = 0;

  function automatic logic [7:0] rd(input logic [23:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  assign mem_ready = mem_req && (wcnt >= waits);
  assign mem_rdata = (mem_req && !mem_we) ? rd(mem_addr) : 8'h00;

  always @(posedge clk)
    if (!rst_n || !mem_req || mem_ready) wcnt <= 0;
    else wcnt <= wcnt + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected accesses as the design performs them
  logic        stall_prev = 1'b0;
  logic [23:0] addr_prev;
  logic [7:0]  wdata_prev;
  logic        we_prev;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        chk(mem_req && mem_addr == addr_prev && mem_we == we_prev && mem_wdata == wdata_prev,
            "R9", "held access addr", {8'h0, mem_addr}, {8'h0, addr_prev});
      stall_prev = mem_req && !mem_ready;
      addr_prev = mem_addr; wdata_prev = mem_wdata; we_prev = mem_we;
      if (mem_req && mem_ready && mem_we) begin
        if (wr_q.size() == 0)
          chk(1'b0, "R2", "unexpected write", {8'h0, mem_addr}, 32'h0);
        else begin
          item_t e;
          e = wr_q.pop_front();
          chk(mem_addr == e.a, "R3", "write addr", {8'h0, mem_addr}, {8'h0, e.a});
          chk(mem_wdata == e.d, "R3", "write data", {24'h0, mem_wdata}, {24'h0, e.d});
        end
        mem[mem_addr] = mem_wdata;
      end
      if (mem_req && mem_ready && !mem_we) begin
        chk(wr_q.size() == 0, "R6", "read before writes finished", wr_q.size(), 0);
        if (rd_q.size() == 0)
          chk(1'b0, "R2", "unexpected read", {8'h0, mem_addr}, 32'h0);
        else begin
          logic [23:0] ea;
          ea = rd_q.pop_front();
          chk(mem_addr == ea, "R6", "vector read addr", {8'h0, mem_addr}, {8'h0, ea});
        end
      end
    end
  end

  // driver: loads vector, queues expectations, fires the trigger
  task automatic run_case(input logic [7:0] vid, input logic [31:0] a, input logic [15:0] p,
                          input logic [15:0] s, input logic [7:0] sb, input logic [15:0] sp,
                          input int w, input logic [15:0] hpc, input logic [7:0] hbank,
                          input bit retrigger);
    logic [7:0]  b[12];
    logic [15:0] va;
    int          n;
    logic [15:0] exp_s;
    va = 16'hFFFC - (16'(vid) << 2);
    mem[{8'hFF, va}]         = hpc[7:0];
    mem[{8'hFF, va + 16'd1}] = hpc[15:8];
    mem[{8'hFF, va + 16'd2}] = hbank;
    b = '{s[15:8], s[7:0], p[15:8], p[7:0], 8'h11, 8'h22, 8'h33, 8'h44,
          a[31:24], a[23:16], a[15:8], a[7:0]};
    for (int k = 0; k < 12; k++) wr_q.push_back({sb, sp - 16'(k + 1), b[k]});  // R4: pre-update status
    for (int k = 0; k < 3; k++) rd_q.push_back({8'hFF, va + 16'(k)});
    exp_s = (s & ~16'h0040) | 16'h0020;
    @(negedge clk);
    waits = w; vec_id = vid; acc = a; pc = p; status = s; sys_bank = sb; sys_sp = sp;
    dpage = 8'h11; addr_bank = 8'h22; data_bank = 8'h33; code_bank = 8'h44;
    swi_go = 1'b1;
    @(negedge clk);
    swi_go = 1'b0;
    status = 16'h0000; pc = 16'h0000; sys_sp = 16'h0000;
    n = 0;
    if (retrigger) begin
      repeat (4) @(negedge clk);
      vec_id = 8'd20; sys_sp = 16'h4000; swi_go = 1'b1;
      @(negedge clk);
      swi_go = 1'b0;
    end
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done, "R10", "done seen", {31'h0, done}, 1);
    chk(!busy && !mem_req, "R10", "idle at done", {30'h0, busy, mem_req}, 0);
    chk(wr_q.size() == 0 && rd_q.size() == 0, "R3", "accesses left", wr_q.size() + rd_q.size(), 0);
    chk(sp_new == sp - 16'd12, "R5", "sp_new", sp_new, sp - 16'd12);
    chk(pc_new == hpc, "R7", "pc_new", pc_new, hpc);
    chk(bank_new == hbank, "R7", "bank_new", bank_new, hbank);
    chk(status_new == exp_s, "R8", "status_new", status_new, exp_s);
    @(negedge clk);
    chk(!done, "R10", "done width", {31'h0, done}, 0);
    if (retrigger) begin
      repeat (40) @(negedge clk);
      chk(!busy && pc_new == hpc, "R2", "retrigger ignored", {15'h0, busy, pc_new}, {16'h0, hpc});
    end
    wr_q.delete(); rd_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1", "control in reset", {29'h0, busy, done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1", "control after reset", {29'h0, busy, done, mem_req}, 0);
    chk(sp_new == 0 && pc_new == 0 && bank_new == 0 && status_new == 0, "R1", "outputs after reset",
        {pc_new, status_new}, 0);
    run_case(8'd11,  32'hDEADBEEF, 16'h1234, 16'hA040, 8'h00, 16'h0800, 0, 16'hC0DE, 8'h7E, 1'b0);
    run_case(8'd0,   32'h01020304, 16'hBEEF, 16'h6020, 8'h12, 16'h8000, 2, 16'h55AA, 8'h01, 1'b0);
    run_case(8'd255, 32'hCAFEF00D, 16'h0F0F, 16'hFFFF, 8'h3C, 16'h0005, 1, 16'h1357, 8'hF0, 1'b0);
    run_case(8'd7,   32'h89ABCDEF, 16'hFEDC, 16'h4040, 8'h00, 16'h0200, 1, 16'h2468, 8'h9A, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule